// File: doc/BRIEF.md
# Event-to-Counter Affinity Allocator

This block hands out hardware event counters. There are ten counters, and each one can count only certain events. A requester supplies an 8-bit event code. The block looks up which counters may count that event, then grants the lowest-numbered one that is both allowed and free. In the same clock edge it records that counter as taken. If every allowed counter is busy, the request fails. The caller is expected to try again later.

A second kind of request returns a counter to the pool. The block keeps the used-counter mask itself, so the caller needs no bookkeeping of its own. The affinity table is built in as combinational logic, so every request takes one cycle. Requests are placed first-come, first-served. The block does not reorder them to fit the most constrained events first.

Top module: `ctr_affinity_alloc`

## Requirements
- R1: An event code with no special rule may use counters 2 through 9 only; counters 0 and 1 are never granted to it, even when they are free.
- R2: Event code 0x02 may use counter 0 as well as counters 2 through 9, so it is granted counter 0 when that counter is free.
- R3: Event code 0x8C may use only counter 1 or counter 7.
- R4: Event codes 0x8D to 0x90, 0x93 to 0x96, 0x98, 0x99, 0x9B, 0x9C, 0xBF to 0xC1, 0xC4 to 0xC6, 0xC8, 0xCA and 0xCB may use only counters 5, 6 and 7.
- R5: Event codes 0x01, 0x97, 0x9A and 0x9F may use only counter 7.
- R6: Event codes 0xF5, 0xF6, 0xF7 and 0xFD may use only counters 2, 4 and 6.
- R7: Event code 0xF8 may use only counters 2 through 7.
- R8: An allocate grants the lowest-numbered counter that is allowed and not in use. That counter counts as used from the very next request on.
- R9: An allocate with no allowed free counter raises the fail flag and leaves the used mask unchanged.
- R10: A free request (req_op = 1) clears the used bit of req_index. Freeing a counter that is not in use has no effect. Freeing an index of 10 or more also has no effect.
- R11: The response appears on the cycle after the request is accepted. An allocate (req_op = 0) yields exactly one of rsp_grant and rsp_fail. A free request yields neither.
- R12: Reset clears the used mask and the response outputs. req_ready stays high, because every request completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_event | input | 8 | Event code for an allocate |
| req_index | input | 4 | Counter index for a free |
| rsp_grant | output | 1 | Allocate succeeded |
| rsp_index | output | 4 | Granted counter index (zero when no grant) |
| rsp_fail | output | 1 | Allocate found no free allowed counter |

## Verification
The hardest cases to reach are the ones where a request fails even though other counters are idle. One example is an event limited to counters 2, 4 and 6 when exactly those three are taken. Another is a plain event while only counters 0 and 1 remain free. The stimulus reaches these states step by step. It fills the counters with events from the narrow groups (counter 7 only, 5 to 7, 2/4/6, 2 to 7) in a planned order, so that the pattern of free counters is known before each critical request. Later it frees single counters, frees them twice, and frees an out-of-range index, then checks with further allocates that exactly one counter came back.

// File: rtl/ctr_alloc_pkg.sv
package ctr_alloc_pkg;
   typedef enum logic {
      OP_ALLOC = 1'b0,
      OP_FREE  = 1'b1
   } alloc_op_e;

   localparam int unsigned TABLE_CTRS  = 10;
   localparam int unsigned TABLE_EVT_W = 8;
endpackage

// File: rtl/ctr_aff_lookup.sv
module ctr_aff_lookup #(
   parameter int unsigned NUM_CTRS = 10,
   parameter int unsigned EVT_W    = 8
) (
   input  logic [EVT_W-1:0]    evt,
   output logic [NUM_CTRS-1:0] allow
);
   localparam logic [NUM_CTRS-1:0] M_DEFAULT = ~NUM_CTRS'(3);
   localparam logic [NUM_CTRS-1:0] M_CYCLES  = M_DEFAULT | NUM_CTRS'(1);
   localparam logic [NUM_CTRS-1:0] M_INSTR   = NUM_CTRS'(10'b00_1000_0010);
   localparam logic [NUM_CTRS-1:0] M_HI3     = NUM_CTRS'(10'b00_1110_0000);
   localparam logic [NUM_CTRS-1:0] M_ONLY7   = NUM_CTRS'(10'b00_1000_0000);
   localparam logic [NUM_CTRS-1:0] M_EVEN3   = NUM_CTRS'(10'b00_0101_0100);
   localparam logic [NUM_CTRS-1:0] M_MID     = NUM_CTRS'(10'b00_1111_1100);

   always_comb begin
      case (evt) inside
         8'h02:                                   allow = M_CYCLES;
         8'h8C:                                   allow = M_INSTR;
         8'h01, 8'h97, 8'h9A, 8'h9F:              allow = M_ONLY7;
         [8'h8D:8'h90], [8'h93:8'h96], 8'h98, 8'h99,
         8'h9B, 8'h9C, [8'hBF:8'hC1], [8'hC4:8'hC6],
         8'hC8, 8'hCA, 8'hCB:                     allow = M_HI3;
         8'hF5, 8'hF6, 8'hF7, 8'hFD:              allow = M_EVEN3;
         8'hF8:                                   allow = M_MID;
         default:                                 allow = M_DEFAULT;
      endcase
   end
endmodule

// File: rtl/ctr_low_pick.sv
module ctr_low_pick #(
   parameter int unsigned N     = 10,
   parameter int unsigned IDX_W = 4
) (
   input  logic [N-1:0]     cand,
   output logic             hit,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign onehot[i]  = cand[i] & ~seen[i];
      assign seen[i+1]  = seen[i] | cand[i];
   end
   assign hit = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (onehot[i]) idx = idx | IDX_W'(i);
      end
   end
endmodule

// File: rtl/ctr_used_bank.sv
module ctr_used_bank #(
   parameter int unsigned N     = 10,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     set_mask,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   output logic [N-1:0]     used
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic clr_hit;
      assign clr_hit = clr_en && (clr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          used[i] <= 1'b0;
         else if (set_mask[i]) used[i] <= 1'b1;
         else if (clr_hit)    used[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/ctr_affinity_alloc.sv
module ctr_affinity_alloc #(
   parameter int unsigned NUM_CTRS = 10,
   parameter int unsigned EVT_W    = 8,
   parameter int unsigned IDX_W    = $clog2(NUM_CTRS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_op,
   input  logic [EVT_W-1:0] req_event,
   input  logic [IDX_W-1:0] req_index,
   output logic             rsp_grant,
   output logic [IDX_W-1:0] rsp_index,
   output logic             rsp_fail
);
   import ctr_alloc_pkg::*;

   if (NUM_CTRS < TABLE_CTRS) begin : g_bad_ctrs
      $error("ctr_affinity_alloc: NUM_CTRS must cover the affinity table");
   end
   if (EVT_W != TABLE_EVT_W) begin : g_bad_evt
      $error("ctr_affinity_alloc: EVT_W must match the event code width");
   end
   if (IDX_W < $clog2(NUM_CTRS)) begin : g_bad_idx
      $error("ctr_affinity_alloc: IDX_W too narrow");
   end

   logic [NUM_CTRS-1:0] allow;
   logic [NUM_CTRS-1:0] used_q;
   logic [NUM_CTRS-1:0] pick_oh;
   logic [NUM_CTRS-1:0] set_mask;
   logic [IDX_W-1:0]    pick_idx;
   logic                pick_hit;
   logic                do_alloc;
   logic                do_free;

   assign req_ready = 1'b1;
   assign do_alloc  = req_valid && (alloc_op_e'(req_op) == OP_ALLOC);
   assign do_free   = req_valid && (alloc_op_e'(req_op) == OP_FREE);

   ctr_aff_lookup #(.NUM_CTRS(NUM_CTRS), .EVT_W(EVT_W)) u_lookup (
      .evt   (req_event),
      .allow (allow)
   );

   ctr_low_pick #(.N(NUM_CTRS), .IDX_W(IDX_W)) u_pick (
      .cand   (allow & ~used_q),
      .hit    (pick_hit),
      .idx    (pick_idx),
      .onehot (pick_oh)
   );

   assign set_mask = do_alloc ? pick_oh : '0;

   ctr_used_bank #(.N(NUM_CTRS), .IDX_W(IDX_W)) u_used (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_mask),
      .clr_en   (do_free),
      .clr_idx  (req_index),
      .used     (used_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_grant <= 1'b0;
         rsp_fail  <= 1'b0;
         rsp_index <= '0;
      end else begin
         rsp_grant <= do_alloc && pick_hit;
         rsp_fail  <= do_alloc && !pick_hit;
         rsp_index <= (do_alloc && pick_hit) ? pick_idx : '0;
      end
   end
endmodule

// File: rtl/ctr_affinity_alloc_chk.sv
module ctr_affinity_alloc_chk #(
   parameter int unsigned NUM_CTRS = 10,
   parameter int unsigned EVT_W    = 8,
   parameter int unsigned IDX_W    = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_op,
   input logic [EVT_W-1:0]    req_event,
   input logic                rsp_grant,
   input logic [IDX_W-1:0]    rsp_index,
   input logic                rsp_fail,
   input logic [NUM_CTRS-1:0] used_q
);
   logic [NUM_CTRS-1:0] grant_bit;
   assign grant_bit = NUM_CTRS'(1) << rsp_index;

   AST_GRANT_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_grant && rsp_fail)); // R11
   AST_ALLOC_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_op) |=> (rsp_grant || rsp_fail)); // R11
   AST_FREE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op) |=> (!rsp_grant && !rsp_fail)); // R11
   AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> (rsp_index < IDX_W'(NUM_CTRS))); // R8
   AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> ((($past(used_q)) & grant_bit) == '0)); // R8
   AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_grant |-> ((used_q & grant_bit) != '0)); // R8
   AST_FAIL_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fail |-> (used_q == $past(used_q))); // R9
   AST_LOW_CTR_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_grant && rsp_index < IDX_W'(2)) |->
         ($past(req_event) == EVT_W'(8'h02) || $past(req_event) == EVT_W'(8'h8C))); // R1
endmodule

bind ctr_affinity_alloc ctr_affinity_alloc_chk #(
   .NUM_CTRS(NUM_CTRS), .EVT_W(EVT_W), .IDX_W(IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_event (req_event),
   .rsp_grant (rsp_grant),
   .rsp_index (rsp_index),
   .rsp_fail  (rsp_fail),
   .used_q    (used_q)
);

// File: tb/ctr_affinity_alloc_test.sv
module ctr_affinity_alloc_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic       req_op = 1'b0;
   logic [7:0] req_event = '0;
   logic [3:0] req_index = '0;
   logic       rsp_grant;
   logic [3:0] rsp_index;
   logic       rsp_fail;

   typedef struct packed {
      logic       g;
      logic       f;
      logic [3:0] idx;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0;
   int    failures = 0;
   logic  seen = 1'b0;
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctr_affinity_alloc uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_event(req_event), .req_index(req_index),
      .rsp_grant(rsp_grant), .rsp_index(rsp_index), .rsp_fail(rsp_fail)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= req_valid;
   end

   // monitor: pops one expectation per accepted request
   always @(negedge clk) begin
      if (seen && exp_q.size() > 0) begin
         exp_t  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rsp_grant !== e.g || rsp_fail !== e.f || rsp_index !== e.idx) begin
            failures++;
            $display("FAIL %s: got grant=%0b fail=%0b idx=%0d, expected grant=%0b fail=%0b idx=%0d",
                     t, rsp_grant, rsp_fail, rsp_index, e.g, e.f, e.idx);
         end
      end
   end

   task automatic drive(input logic op, input logic [7:0] evt, input logic [3:0] idx,
                        input logic eg, input logic ef, input logic [3:0] eidx,
                        input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = op;
      req_event = evt;
      req_index = idx;
      e.g = eg; e.f = ef; e.idx = eidx;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic alloc_ok(input logic [7:0] evt, input logic [3:0] idx, input string tag);
      drive(1'b0, evt, 4'd0, 1'b1, 1'b0, idx, tag);
   endtask

   task automatic alloc_fail(input logic [7:0] evt, input string tag);
      drive(1'b0, evt, 4'd0, 1'b0, 1'b1, 4'd0, tag);
   endtask

   task automatic free_ctr(input logic [3:0] idx, input string tag);
      drive(1'b1, 8'h00, idx, 1'b0, 1'b0, 4'd0, tag);
   endtask

   task automatic idle_flush();
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic check_reset_state(input string tag);
      checks++;
      if (rsp_grant !== 1'b0 || rsp_fail !== 1'b0 || rsp_index !== 4'd0 || req_ready !== 1'b1) begin
         failures++;
         $display("FAIL %s: got grant=%0b fail=%0b idx=%0d ready=%0b, expected 0 0 0 1",
                  tag, rsp_grant, rsp_fail, rsp_index, req_ready);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state("R12 reset outputs");
      rst_n = 1'b1;

      alloc_ok  (8'h8C, 4'd1, "R3 instr first to ctr1");
      alloc_ok  (8'h8C, 4'd7, "R3 instr second to ctr7");
      alloc_fail(8'h8C,       "R3 R9 instr third fails");
      free_ctr  (4'd7,        "R11 free gives no response");
      alloc_ok  (8'h8D, 4'd5, "R4 group to ctr5");
      alloc_ok  (8'hC4, 4'd6, "R4 group to ctr6");
      alloc_ok  (8'hCB, 4'd7, "R4 group to ctr7");
      alloc_fail(8'h90,       "R4 group exhausted");
      alloc_fail(8'h97,       "R5 only ctr7 busy");
      free_ctr  (4'd7,        "R10 free ctr7");
      alloc_ok  (8'h9A, 4'd7, "R5 only ctr7 reused");
      alloc_ok  (8'h02, 4'd0, "R2 cycles takes ctr0");
      alloc_ok  (8'h02, 4'd2, "R2 R8 cycles next lowest");
      alloc_ok  (8'hF5, 4'd4, "R6 even group skips busy ctr2");
      alloc_fail(8'hFD,       "R6 R9 even group exhausted");
      alloc_ok  (8'hF8, 4'd3, "R7 mid range ctr3");
      alloc_fail(8'hF8,       "R7 mid range exhausted");
      alloc_ok  (8'h10, 4'd8, "R1 default to ctr8");
      alloc_ok  (8'h55, 4'd9, "R1 default to ctr9");
      alloc_fail(8'h33,       "R1 R9 all busy");
      free_ctr  (4'd3,        "R10 free ctr3");
      free_ctr  (4'd3,        "R10 double free");
      alloc_ok  (8'h10, 4'd3, "R10 freed ctr3 granted");
      alloc_fail(8'h10,       "R10 double free gave nothing back");
      free_ctr  (4'd12,       "R10 out of range free");
      alloc_fail(8'h20,       "R10 out of range free ignored");
      free_ctr  (4'd0,        "R10 free ctr0");
      alloc_fail(8'h10,       "R1 default never gets ctr0");
      alloc_ok  (8'h02, 4'd0, "R2 cycles regains ctr0");
      idle_flush();

      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("R12 reset mid run");
      rst_n = 1'b1;
      alloc_ok  (8'h01, 4'd7, "R12 R5 mask cleared by reset");
      alloc_ok  (8'h8C, 4'd1, "R12 R3 mask cleared by reset");
      alloc_ok  (8'hF6, 4'd2, "R6 R8 lowest of even group");
      alloc_ok  (8'hF7, 4'd4, "R6 R8 back to back");
      idle_flush();

      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R11: %0d responses missing, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, got timeout, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule